// File: doc/BRIEF.md
# Decode-and-Execute Stage with Condition Flags

This block is the decode and execute stage of a small 32-bit RISC with three operands. Each cycle it may accept one instruction word, along with the two register values the register file read for it. It picks apart the destination, source and immediate fields and selects the second operand, which is either the register value or the sign-extended 16-bit immediate. It then runs an add, a subtract, one of four bitwise operations, or a shift or rotate by one, two or four places. No barrel shifter is present. One cycle later it presents the write-back request, the effect on memory and the outcome of a jump, all registered.

The four condition flags (zero, negative, carry, overflow) live inside the block. How they are updated depends on the instruction class. Loads, stores and jumps reuse the same adder to form their effective address. A load's data is handed back through a separate return port, so the block can write it back and set the zero and negative flags from it. Register storage, fetch, memory access and pipeline control sit outside the block.

Top module: `rx_exec_unit`

## Requirements
- R1: In the ALU form, bit 31 is 0 and bits 30:27 hold the operation. Bit 26 selects the second operand: 0 takes `opb_i`, and 1 takes the immediate in bits 15:0, sign-extended to 32 bits. The destination is bits 25:21, so all 32 registers, r0 included, are written like any other.
- R2: ALU operation codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR and 5 XNOR. The write-back data appears on `wb_data_o` with `wb_en_o` high one cycle after the instruction is accepted.
- R3: Subtract computes a + ~b + 1. For add and subtract, C is the carry out of the 32-bit sum. V is set when the two adder inputs share a sign and the sum's sign differs from it.
- R4: Codes 6, 7, 8 and 9 are shift left logical, shift right logical, rotate left and rotate right. The amount comes from bits 1:0 of the second operand: 00 selects 1, 01 selects 2, and 1x selects 4.
- R5: `flags_o` is {Z,N,C,V}, with Z in bit 3. Add and subtract update all four flags. Bitwise and shift operations update Z and N and leave C and V unchanged.
- R6: In the memory/jump form, bit 31 is 1, bits 30:26 hold the class (0 load, 1 store, 2 conditional jump, 3 jump-and-link), and rd, ra and imm sit where they do in the ALU form. The effective address is ra plus the sign-extended immediate.
- R7: A load raises `mem_rd_o` with the address on `mem_addr_o`. A store raises `mem_wr_o` with the address and with `opb_i` on `mem_wdata_o`. Neither writes back, and a store leaves every flag unchanged.
- R8: A conditional jump takes its condition from bits 24:21 and tests the flags as they stood before it: 0 always, 1 Z, 2 !Z, 3 N, 4 !N, 5 C, 6 !C, 7 V, 8 !V, and any other value never. When taken, `jump_o` is high and `jump_target_o` holds the effective address. The jump neither writes back nor changes flags.
- R9: Jump-and-link always jumps to the effective address and writes `pc_i + 4` to rd. Flags stay unchanged.
- R10: A load return (`ldret_valid_i`) writes `ldret_data_i` to `ldret_rd_i` and updates Z and N from that data. C and V are kept.
- R11: ALU codes 10 to 15, memory/jump classes 4 to 31, and idle cycles cause no write-back, no memory access and no jump, and leave the flags unchanged.
- R12: Reset clears every output, flags included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 32 | Value of register ra |
| opb_i | input | 32 | Value of register rb (ALU form) or of rd (store) |
| pc_i | input | 32 | Address of the instruction |
| ldret_valid_i | input | 1 | Load data returning this cycle; never together with in_valid_i |
| ldret_rd_i | input | 5 | Destination of the returning load |
| ldret_data_i | input | 32 | Returned load data |
| wb_en_o | output | 1 | Register write request |
| wb_rd_o | output | 5 | Register to write |
| wb_data_o | output | 32 | Data to write |
| flags_o | output | 4 | {Z,N,C,V} |
| jump_o | output | 1 | Jump taken |
| jump_target_o | output | 32 | Jump destination |
| mem_rd_o | output | 1 | Load request |
| mem_wr_o | output | 1 | Store request |
| mem_addr_o | output | 32 | Effective address |
| mem_wdata_o | output | 32 | Store data |

## Verification
The assertions check, on every cycle, the rules that involve no arithmetic. Stores and plain jumps never write back. At most one of load, store and jump is raised. Flags hold across stores, jumps and idle cycles. Carry and overflow hold across zero/negative-only updates, and Z always matches the written data for those updates. Only the bench's scenarios can show the arithmetic itself: carry and overflow on the add and subtract edge values, the shift and rotate amounts, the sign extension of negative immediates, the condition table, and the link address.

// File: rtl/rx_exec_pkg.sv
package rx_exec_pkg;
    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int IMM_W   = 16;
    localparam int ALUOP_W = 4;
    localparam int MCLS_W  = 5;
    localparam int COND_W  = 4;
    localparam int FLAG_W  = 4;

    localparam int FZ = 3;
    localparam int FN = 2;
    localparam int FC = 1;
    localparam int FV = 0;

    localparam logic [ALUOP_W-1:0] OP_ADD  = 4'd0;
    localparam logic [ALUOP_W-1:0] OP_SUB  = 4'd1;
    localparam logic [ALUOP_W-1:0] OP_AND  = 4'd2;
    localparam logic [ALUOP_W-1:0] OP_OR   = 4'd3;
    localparam logic [ALUOP_W-1:0] OP_XOR  = 4'd4;
    localparam logic [ALUOP_W-1:0] OP_XNOR = 4'd5;
    localparam logic [ALUOP_W-1:0] OP_SHL  = 4'd6;
    localparam logic [ALUOP_W-1:0] OP_SHR  = 4'd7;
    localparam logic [ALUOP_W-1:0] OP_ROL  = 4'd8;
    localparam logic [ALUOP_W-1:0] OP_ROR  = 4'd9;

    localparam logic [MCLS_W-1:0] MC_LOAD  = 5'd0;
    localparam logic [MCLS_W-1:0] MC_STORE = 5'd1;
    localparam logic [MCLS_W-1:0] MC_JUMP  = 5'd2;
    localparam logic [MCLS_W-1:0] MC_JAL   = 5'd3;

    typedef enum logic [1:0] {
        FU_NONE = 2'd0,
        FU_ZN   = 2'd1,
        FU_ZNCV = 2'd2
    } flag_upd_e;

    typedef struct packed {
        logic                valid;
        logic [ALUOP_W-1:0]  alu_op;
        logic                sel_imm;
        logic [REG_AW-1:0]   rd;
        logic [XLEN-1:0]     imm_ext;
        logic                wr_en;
        logic                is_load;
        logic                is_store;
        logic                is_jump;
        logic                is_link;
        logic [COND_W-1:0]   cond;
        flag_upd_e           fupd;
    } dec_s;

    typedef struct packed {
        logic                wb_en;
        logic [REG_AW-1:0]   wb_rd;
        logic [XLEN-1:0]     wb_data;
        logic [FLAG_W-1:0]   flags;
        logic                jump;
        logic [XLEN-1:0]     jtarget;
        logic                mem_rd;
        logic                mem_wr;
        logic [XLEN-1:0]     maddr;
        logic [XLEN-1:0]     mwdata;
        logic                zn_only;
    } exec_state_s;
endpackage

// File: rtl/rx_decode.sv
module rx_decode
    import rx_exec_pkg::*;
(
    input  logic            valid_i,
    input  logic [XLEN-1:0] insn_i,
    output dec_s            dec_o
);
    localparam int OP_LSB  = XLEN - 1 - ALUOP_W;
    localparam int SEL_BIT = OP_LSB - 1;
    localparam int RD_LSB  = SEL_BIT - REG_AW;
    localparam int MC_LSB  = XLEN - 1 - MCLS_W;

    logic                is_mem;
    logic [ALUOP_W-1:0]  op_raw;
    logic [MCLS_W-1:0]   mc_raw;

    always_comb begin
        is_mem = insn_i[XLEN-1];
        op_raw = insn_i[XLEN-2:OP_LSB];
        mc_raw = insn_i[XLEN-2:MC_LSB];

        dec_o          = '0;
        dec_o.rd       = insn_i[RD_LSB +: REG_AW];
        dec_o.cond     = insn_i[RD_LSB +: COND_W];
        dec_o.imm_ext  = {{(XLEN-IMM_W){insn_i[IMM_W-1]}}, insn_i[IMM_W-1:0]};
        dec_o.fupd     = FU_NONE;

        if (!is_mem) begin
            dec_o.alu_op  = op_raw;
            dec_o.sel_imm = insn_i[SEL_BIT];
            if (op_raw <= OP_ROR) begin
                dec_o.valid = valid_i;
                dec_o.wr_en = 1'b1;
                dec_o.fupd  = (op_raw == OP_ADD || op_raw == OP_SUB) ? FU_ZNCV : FU_ZN;
            end
        end else begin
            dec_o.alu_op  = OP_ADD;
            dec_o.sel_imm = 1'b1;
            case (mc_raw)
                MC_LOAD: begin
                    dec_o.valid   = valid_i;
                    dec_o.is_load = 1'b1;
                end
                MC_STORE: begin
                    dec_o.valid    = valid_i;
                    dec_o.is_store = 1'b1;
                end
                MC_JUMP: begin
                    dec_o.valid   = valid_i;
                    dec_o.is_jump = 1'b1;
                end
                MC_JAL: begin
                    dec_o.valid   = valid_i;
                    dec_o.is_link = 1'b1;
                    dec_o.wr_en   = 1'b1;
                end
                default: dec_o.valid = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/rx_alu.sv
module rx_alu
    import rx_exec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [ALUOP_W-1:0] op_i,
    input  logic [W-1:0]       a_i,
    input  logic [W-1:0]       b_i,
    output logic [W-1:0]       res_o,
    output logic               carry_o,
    output logic               ovf_o
);
    localparam int NUM_SH = 3;

    logic [W-1:0] shl_c [NUM_SH];
    logic [W-1:0] shr_c [NUM_SH];
    logic [W-1:0] rol_c [NUM_SH];
    logic [W-1:0] ror_c [NUM_SH];

    for (genvar k = 0; k < NUM_SH; k++) begin : g_sh
        localparam int SH = 1 << k;
        assign shl_c[k] = a_i << SH;
        assign shr_c[k] = a_i >> SH;
        assign rol_c[k] = (a_i << SH) | (a_i >> (W - SH));
        assign ror_c[k] = (a_i >> SH) | (a_i << (W - SH));
    end

    logic         is_sub;
    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic [1:0]   sh_sel;

    always_comb begin
        is_sub  = (op_i == OP_SUB);
        b_eff   = is_sub ? ~b_i : b_i;
        sum     = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
        carry_o = sum[W];
        ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);
        sh_sel  = b_i[1] ? 2'd2 : (b_i[0] ? 2'd1 : 2'd0);

        case (op_i)
            OP_ADD,
            OP_SUB:  res_o = sum[W-1:0];
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_XNOR: res_o = ~(a_i ^ b_i);
            OP_SHL:  res_o = shl_c[sh_sel];
            OP_SHR:  res_o = shr_c[sh_sel];
            OP_ROL:  res_o = rol_c[sh_sel];
            OP_ROR:  res_o = ror_c[sh_sel];
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/rx_flags.sv
module rx_flags
    import rx_exec_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_q_i,
    input  flag_upd_e         fupd_i,
    input  logic [XLEN-1:0]   res_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    input  logic [COND_W-1:0] cond_i,
    output logic [FLAG_W-1:0] flags_d_o,
    output logic              cond_ok_o
);
    always_comb begin
        flags_d_o = flags_q_i;
        if (fupd_i != FU_NONE) begin
            flags_d_o[FZ] = (res_i == '0);
            flags_d_o[FN] = res_i[XLEN-1];
        end
        if (fupd_i == FU_ZNCV) begin
            flags_d_o[FC] = carry_i;
            flags_d_o[FV] = ovf_i;
        end

        case (cond_i)
            4'd0:    cond_ok_o = 1'b1;
            4'd1:    cond_ok_o =  flags_q_i[FZ];
            4'd2:    cond_ok_o = !flags_q_i[FZ];
            4'd3:    cond_ok_o =  flags_q_i[FN];
            4'd4:    cond_ok_o = !flags_q_i[FN];
            4'd5:    cond_ok_o =  flags_q_i[FC];
            4'd6:    cond_ok_o = !flags_q_i[FC];
            4'd7:    cond_ok_o =  flags_q_i[FV];
            4'd8:    cond_ok_o = !flags_q_i[FV];
            default: cond_ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rx_exec_unit.sv
module rx_exec_unit
    import rx_exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [31:0]       insn_i,
    input  logic [31:0]       opa_i,
    input  logic [31:0]       opb_i,
    input  logic [31:0]       pc_i,
    input  logic              ldret_valid_i,
    input  logic [4:0]        ldret_rd_i,
    input  logic [31:0]       ldret_data_i,
    output logic              wb_en_o,
    output logic [4:0]        wb_rd_o,
    output logic [31:0]       wb_data_o,
    output logic [3:0]        flags_o,
    output logic              jump_o,
    output logic [31:0]       jump_target_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o
);
    localparam logic [XLEN-1:0] LINK_STEP = XLEN'(4);

    exec_state_s st_d, st_q;
    dec_s        dec;

    logic [XLEN-1:0] opb_sel;
    logic [XLEN-1:0] alu_res;
    logic            alu_c;
    logic            alu_v;
    logic [FLAG_W-1:0] flags_nx;
    logic            cond_ok;
    flag_upd_e       fupd_sel;
    logic [XLEN-1:0] fres_sel;

    rx_decode u_dec (
        .valid_i (in_valid_i),
        .insn_i  (insn_i),
        .dec_o   (dec)
    );

    assign opb_sel = dec.sel_imm ? dec.imm_ext : opb_i;

    rx_alu #(.W(XLEN)) u_alu (
        .op_i    (dec.alu_op),
        .a_i     (opa_i),
        .b_i     (opb_sel),
        .res_o   (alu_res),
        .carry_o (alu_c),
        .ovf_o   (alu_v)
    );

    always_comb begin
        if (ldret_valid_i) begin
            fupd_sel = FU_ZN;
            fres_sel = ldret_data_i;
        end else if (dec.valid) begin
            fupd_sel = dec.fupd;
            fres_sel = alu_res;
        end else begin
            fupd_sel = FU_NONE;
            fres_sel = alu_res;
        end
    end

    rx_flags u_flags (
        .flags_q_i (st_q.flags),
        .fupd_i    (fupd_sel),
        .res_i     (fres_sel),
        .carry_i   (alu_c),
        .ovf_i     (alu_v),
        .cond_i    (dec.cond),
        .flags_d_o (flags_nx),
        .cond_ok_o (cond_ok)
    );

    always_comb begin
        st_d         = '0;
        st_d.flags   = flags_nx;
        st_d.zn_only = (fupd_sel == FU_ZN);
        if (ldret_valid_i) begin
            st_d.wb_en   = 1'b1;
            st_d.wb_rd   = ldret_rd_i;
            st_d.wb_data = ldret_data_i;
        end else if (dec.valid) begin
            st_d.wb_en   = dec.wr_en;
            st_d.wb_rd   = dec.rd;
            st_d.wb_data = dec.is_link ? (pc_i + LINK_STEP) : alu_res;
            st_d.jump    = dec.is_link | (dec.is_jump & cond_ok);
            st_d.jtarget = (dec.is_link | dec.is_jump) ? alu_res : '0;
            st_d.mem_rd  = dec.is_load;
            st_d.mem_wr  = dec.is_store;
            st_d.maddr   = (dec.is_load | dec.is_store) ? alu_res : '0;
            st_d.mwdata  = dec.is_store ? opb_i : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_en_o       = st_q.wb_en;
    assign wb_rd_o       = st_q.wb_rd;
    assign wb_data_o     = st_q.wb_data;
    assign flags_o       = st_q.flags;
    assign jump_o        = st_q.jump;
    assign jump_target_o = st_q.jtarget;
    assign mem_rd_o      = st_q.mem_rd;
    assign mem_wr_o      = st_q.mem_wr;
    assign mem_addr_o    = st_q.maddr;
    assign mem_wdata_o   = st_q.mwdata;

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> !wb_en_o);  // R7
    AST_STORE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> $stable(flags_o));  // R7
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o, jump_o}));  // R6
    AST_JUMP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> $stable(flags_o));  // R8
    AST_ZN_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.zn_only |-> $stable(flags_o[FC:FV]));  // R5
    AST_ZN_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.zn_only |-> (flags_o[FZ] == (wb_data_o == '0)));  // R10
    AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_valid_i && !ldret_valid_i) |-> $stable(flags_o));  // R11
    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid_i && ldret_valid_i));  // R10
endmodule

// File: tb/rx_exec_unit_tb_top.sv
module rx_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid_i;
    logic [31:0] insn_i, opa_i, opb_i, pc_i;
    logic        ldret_valid_i;
    logic [4:0]  ldret_rd_i;
    logic [31:0] ldret_data_i;
    logic        wb_en_o, jump_o, mem_rd_o, mem_wr_o;
    logic [4:0]  wb_rd_o;
    logic [31:0] wb_data_o, jump_target_o, mem_addr_o, mem_wdata_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rx_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .insn_i(insn_i),
        .opa_i(opa_i), .opb_i(opb_i), .pc_i(pc_i),
        .ldret_valid_i(ldret_valid_i), .ldret_rd_i(ldret_rd_i), .ldret_data_i(ldret_data_i),
        .wb_en_o(wb_en_o), .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o), .flags_o(flags_o),
        .jump_o(jump_o), .jump_target_o(jump_target_o), .mem_rd_o(mem_rd_o),
        .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    typedef struct packed {
        logic        imm;
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic [3:0]  fl;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0, 32'h5,        32'h7,        32'hC,        4'b0000}, // R2 add
        '{1'b0, 4'd0, 32'hFFFFFFFF, 32'h1,        32'h0,        4'b1010}, // R3 carry
        '{1'b0, 4'd0, 32'h7FFFFFFF, 32'h1,        32'h80000000, 4'b0101}, // R3 ovf
        '{1'b0, 4'd1, 32'h5,        32'h5,        32'h0,        4'b1010}, // R3 sub equal
        '{1'b0, 4'd1, 32'h3,        32'h5,        32'hFFFFFFFE, 4'b0100}, // R3 borrow
        '{1'b0, 4'd1, 32'h80000000, 32'h1,        32'h7FFFFFFF, 4'b0011}, // R3 sub ovf
        '{1'b0, 4'd2, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'h0,        4'b1011}, // R5 and
        '{1'b1, 4'd3, 32'h10,       32'h0000FFFF, 32'hFFFFFFFF, 4'b0111}, // R1 or imm
        '{1'b0, 4'd4, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h0,        4'b1011}, // R2 xor
        '{1'b0, 4'd5, 32'h0,        32'h0,        32'hFFFFFFFF, 4'b0111}, // R2 xnor
        '{1'b0, 4'd6, 32'h12345678, 32'h2,        32'h23456780, 4'b0011}, // R4 shl4
        '{1'b0, 4'd7, 32'h80000001, 32'h0,        32'h40000000, 4'b0011}, // R4 shr1
        '{1'b0, 4'd8, 32'hC0000001, 32'h1,        32'h00000007, 4'b0011}, // R4 rol2
        '{1'b0, 4'd9, 32'h0000000F, 32'h2,        32'hF0000000, 4'b0111}, // R4 ror4
        '{1'b1, 4'd0, 32'hA,        32'h0000FFFE, 32'h8,        4'b0010}  // R1 neg imm
    };

    function automatic logic [31:0] alu_w(logic imm, logic [3:0] op, logic [4:0] rd,
                                          logic [4:0] ra, logic [15:0] low);
        return {1'b0, op, imm, rd, ra, low};
    endfunction

    function automatic logic [31:0] mem_w(logic [4:0] cls, logic [4:0] rd,
                                          logic [4:0] ra, logic [15:0] imm);
        return {1'b1, cls, rd, ra, imm};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] insn, logic [31:0] a, logic [31:0] b, logic [31:0] pc);
        @(negedge clk);
        in_valid_i = 1'b1; insn_i = insn; opa_i = a; opb_i = b; pc_i = pc;
        @(posedge clk); #1;
        in_valid_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid_i = 1'b0; insn_i = '0; opa_i = '0; opb_i = '0; pc_i = '0;
        ldret_valid_i = 1'b0; ldret_rd_i = '0; ldret_data_i = '0;
        repeat (3) @(posedge clk); #1;
        chk("R12", "reset wb_en", {31'b0, wb_en_o}, 32'h0);
        chk("R12", "reset flags", {28'b0, flags_o}, 32'h0);
        chk("R12", "reset jump/mem", {29'b0, jump_o, mem_rd_o, mem_wr_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] w;
            w = VECS[i].imm ? alu_w(1'b1, VECS[i].op, 5'(i), 5'd2, VECS[i].b[15:0])
                            : alu_w(1'b0, VECS[i].op, 5'(i), 5'd2, {5'd3, 11'd0});
            issue(w, VECS[i].a, VECS[i].b, 32'h0);
            chk("R2", $sformatf("vec%0d data", i), wb_data_o, VECS[i].exp);
            chk("R1", $sformatf("vec%0d rd", i), {27'b0, wb_rd_o}, 32'(i));
            chk("R2", $sformatf("vec%0d wb_en", i), {31'b0, wb_en_o}, 32'h1);
            chk("R5", $sformatf("vec%0d flags", i), {28'b0, flags_o}, {28'b0, VECS[i].fl});
        end
        // flags now 0010 (C only)

        issue(mem_w(5'd2, 5'd5, 5'd1, 16'hFFF0), 32'h1000, 32'h0, 32'h0);
        chk("R8", "jump on C taken", {31'b0, jump_o}, 32'h1);
        chk("R8", "jump target", jump_target_o, 32'h00000FF0);
        chk("R8", "jump no wb", {31'b0, wb_en_o}, 32'h0);
        chk("R8", "jump flags kept", {28'b0, flags_o}, 32'h2);

        issue(mem_w(5'd2, 5'd1, 5'd1, 16'h0010), 32'h1000, 32'h0, 32'h0);
        chk("R8", "jump on Z not taken", {31'b0, jump_o}, 32'h0);
        issue(mem_w(5'd2, 5'd6, 5'd1, 16'h0010), 32'h1000, 32'h0, 32'h0);
        chk("R8", "jump on !C not taken", {31'b0, jump_o}, 32'h0);
        issue(mem_w(5'd2, 5'd9, 5'd1, 16'h0010), 32'h1000, 32'h0, 32'h0);
        chk("R8", "cond 9 never", {31'b0, jump_o}, 32'h0);

        issue(mem_w(5'd3, 5'd31, 5'd1, 16'h0008), 32'h4000, 32'h0, 32'h200);
        chk("R9", "jal jump", {31'b0, jump_o}, 32'h1);
        chk("R9", "jal target", jump_target_o, 32'h4008);
        chk("R9", "jal link", wb_data_o, 32'h204);
        chk("R9", "jal rd", {27'b0, wb_rd_o}, 32'd31);
        chk("R9", "jal flags", {28'b0, flags_o}, 32'h2);

        issue(mem_w(5'd1, 5'd3, 5'd1, 16'h0004), 32'h100, 32'hDEADBEEF, 32'h0);
        chk("R7", "store wr", {31'b0, mem_wr_o}, 32'h1);
        chk("R7", "store addr", mem_addr_o, 32'h104);
        chk("R7", "store data", mem_wdata_o, 32'hDEADBEEF);
        chk("R7", "store no wb", {31'b0, wb_en_o}, 32'h0);
        chk("R7", "store flags", {28'b0, flags_o}, 32'h2);

        issue(mem_w(5'd0, 5'd7, 5'd1, 16'hFFFC), 32'h100, 32'h0, 32'h0);
        chk("R6", "load rd req", {31'b0, mem_rd_o}, 32'h1);
        chk("R6", "load addr", mem_addr_o, 32'hFC);
        chk("R7", "load no wb", {31'b0, wb_en_o}, 32'h0);

        @(negedge clk);
        ldret_valid_i = 1'b1; ldret_rd_i = 5'd7; ldret_data_i = 32'h0;
        @(posedge clk); #1; ldret_valid_i = 1'b0;
        chk("R10", "ldret wb", {26'b0, wb_en_o, wb_rd_o}, {26'b0, 1'b1, 5'd7});
        chk("R10", "ldret flags", {28'b0, flags_o}, 32'hA);

        issue(alu_w(1'b0, 4'd12, 5'd4, 5'd1, 16'h0), 32'h0, 32'h0, 32'h0);
        chk("R11", "reserved op no wb", {31'b0, wb_en_o}, 32'h0);
        chk("R11", "reserved op flags", {28'b0, flags_o}, 32'hA);
        issue(mem_w(5'd9, 5'd4, 5'd1, 16'h0), 32'h0, 32'h0, 32'h0);
        chk("R11", "reserved class inert", {29'b0, jump_o, mem_rd_o, mem_wr_o}, 32'h0);
        @(posedge clk); #1;
        chk("R11", "idle no wb", {31'b0, wb_en_o}, 32'h0);
        chk("R11", "idle flags", {28'b0, flags_o}, 32'hA);

        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R12", "reset clears flags", {28'b0, flags_o}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule